// File: doc/BRIEF.md
# Automatic Xon/Xoff Transmit Flow Controller

This block gives a UART automatic software flow control. It sees every character the receiver delivers. It compares each one with four programmable characters: two that mean "resume" and two that mean "pause". When one of them matches, it gates the transmitter on or off. The host takes no part in this. When a pause is recognised, it sets a status flag, and that flag can raise an interrupt if the interrupt is unmasked. Characters that do not belong to a flow-control match are passed on to the receive FIFO write port one cycle later.

A two-bit mode field selects the matching scheme: off, one character each way, or a pair of characters each way. An optional resume-on-anything mode lets any received character end a pause. The transmit gate only stops new characters from starting. A character already being shifted out finishes normally. A separate output reports when the line has actually gone quiet.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: While `rst` is high and after its release, `tx_go` is 1 and `tx_halted`, `rxf_wr`, `xoff_seen` and `irq` are 0.
- R2: `fc_mode` encoding: 2'b00 disables matching (every byte is forwarded, and any pause is dropped at the next edge); 2'b01 selects single characters; 2'b10 and 2'b11 both select character pairs.
- R3: In single mode, a valid byte equal to `xoff1_char` drives `tx_go` low after that edge. A byte equal to `xon1_char` drives it high. If both compare equal, pausing wins.
- R4: In pair mode, a pause needs `xoff1_char` followed by `xoff2_char` as consecutive valid bytes, and a resume needs `xon1_char` followed by `xon2_char`. Clock cycles without a valid byte between them do not break the pair. Any other valid byte between them cancels the partial match.
- R5: A byte that completes a flow-control match is consumed, so `rxf_wr` stays 0 after that edge. Every other valid byte appears on `rxf_data` with `rxf_wr` high one cycle later. In pair mode the first byte of a pair is forwarded.
- R6: With `xon_any` high while paused, any valid byte that is not itself a pause match resumes transmission. That byte is forwarded unless it is itself a resume match.
- R7: `xoff_seen` is set one cycle after a pause match. It is cleared after a cycle with `isr_rd` high. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` equals the next value of `xoff_seen` ANDed with `xoff_irq_en`, registered, so it is 0 one cycle after `xoff_irq_en` is low.
- R9: `tx_halted` is 1 one cycle after an edge at which the controller is paused (after that edge's update) and `tx_idle` is high. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| fc_mode | input | 2 | Matching mode (off, single, pair) |
| xon_any | input | 1 | Any received byte resumes while paused |
| xoff_irq_en | input | 1 | Interrupt mask for the pause flag |
| xon1_char | input | DW | First resume character |
| xon2_char | input | DW | Second resume character |
| xoff1_char | input | DW | First pause character |
| xoff2_char | input | DW | Second pause character |
| tx_idle | input | 1 | Transmit shifter has no character in flight |
| isr_rd | input | 1 | Interrupt status read strobe, clears the flag |
| tx_go | output | 1 | Transmitter may start a new character |
| tx_halted | output | 1 | Paused and the line is idle |
| rxf_wr | output | 1 | Write strobe to the receive FIFO |
| rxf_data | output | DW | Byte for the receive FIFO |
| xoff_seen | output | 1 | Pause-received status flag |
| irq | output | 1 | Masked interrupt request |

## Verification
Two functions can land on the same edge. One is a pause match setting `xoff_seen`, the other a status read clearing it. The bench drives a pause character and `isr_rd` in one cycle and expects the flag to stay set. It then reads once more and expects the flag to clear. A second overlap is a resume-on-anything byte that is itself a pause or resume character. It is provoked by sweeping every byte value while paused with `xon_any` high. Each result is judged against a bench model of pausing, consumption and forwarding.

// File: rtl/swfc_pkg.sv
`timescale 1ns/1ps
package swfc_pkg;
  typedef enum logic [1:0] {
    FC_OFF      = 2'b00,
    FC_SINGLE   = 2'b01,
    FC_PAIR     = 2'b10,
    FC_PAIR_ALT = 2'b11
  } fc_mode_e;

  localparam int unsigned SEQ_RESUME = 0;
  localparam int unsigned SEQ_PAUSE  = 1;
  localparam int unsigned NUM_SEQ    = 2;
endpackage

// File: rtl/swfc_seq_match.sv
`timescale 1ns/1ps
// One flow-control sequence matcher: single character or ordered pair.
module swfc_seq_match #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          single_en,
  input  logic          pair_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] lead,
  input  logic [DW-1:0] trail,
  output logic          hit
);
  logic armed_q;

  always_comb begin
    hit = 1'b0;
    if (rx_valid) begin
      if (single_en)    hit = (rx_byte == lead);
      else if (pair_en) hit = armed_q && (rx_byte == trail);
    end
  end

  // Partial match is held across idle cycles; any valid byte re-evaluates it.
  always_ff @(posedge clk) begin
    if (rst || !pair_en)  armed_q <= 1'b0;
    else if (rx_valid)    armed_q <= (rx_byte == lead);
  end

  p_break_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (pair_en && rx_valid && rx_byte != lead) |=> !armed_q);
endmodule

// File: rtl/swfc_gate.sv
`timescale 1ns/1ps
// Pause state and the transmit gate.
module swfc_gate (
  input  logic clk,
  input  logic rst,
  input  logic fc_on,
  input  logic rx_valid,
  input  logic pause_hit,
  input  logic resume_hit,
  input  logic xon_any,
  input  logic tx_idle,
  output logic tx_go,
  output logic tx_halted
);
  logic paused_q, paused_nxt, halted_q;

  always_comb begin
    paused_nxt = paused_q;
    if (!fc_on)                                paused_nxt = 1'b0;
    else if (pause_hit)                        paused_nxt = 1'b1;
    else if (resume_hit)                       paused_nxt = 1'b0;
    else if (paused_q && xon_any && rx_valid)  paused_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paused_q <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      paused_q <= paused_nxt;
      halted_q <= paused_nxt && tx_idle;
    end
  end

  assign tx_go     = !paused_q;
  assign tx_halted = halted_q;

  p_pause_r3: assert property (@(posedge clk) disable iff (rst)
    (fc_on && pause_hit) |=> !tx_go);
  p_resume_r3: assert property (@(posedge clk) disable iff (rst)
    (resume_hit && !pause_hit) |=> tx_go);
  p_any_resumes_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && xon_any && !pause_hit) |=> tx_go);
  p_off_runs_r2: assert property (@(posedge clk) disable iff (rst)
    !fc_on |=> tx_go);
  p_halt_only_paused_r9: assert property (@(posedge clk) disable iff (rst)
    tx_halted |-> !tx_go);
endmodule

// File: rtl/swfc_irq.sv
`timescale 1ns/1ps
// Pause-received status flag and its masked interrupt.
module swfc_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_nxt, irq_q;

  always_comb begin
    flag_nxt = flag_q;
    if (set)      flag_nxt = 1'b1;
    else if (clr) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt && irq_en;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
  p_masked_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl
  import swfc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [1:0]    fc_mode,
  input  logic          xon_any,
  input  logic          xoff_irq_en,
  input  logic [DW-1:0] xon1_char,
  input  logic [DW-1:0] xon2_char,
  input  logic [DW-1:0] xoff1_char,
  input  logic [DW-1:0] xoff2_char,
  input  logic          tx_idle,
  input  logic          isr_rd,
  output logic          tx_go,
  output logic          tx_halted,
  output logic          rxf_wr,
  output logic [DW-1:0] rxf_data,
  output logic          xoff_seen,
  output logic          irq
);
  fc_mode_e mode;
  logic single_en, pair_en, fc_on, any_hit;
  logic [NUM_SEQ-1:0]         seq_hit;
  logic [NUM_SEQ-1:0][DW-1:0] lead_c, trail_c;
  logic          wr_q;
  logic [DW-1:0] data_q;

  assign mode      = fc_mode_e'(fc_mode);
  assign fc_on     = (mode != FC_OFF);
  assign single_en = (mode == FC_SINGLE);
  assign pair_en   = (mode == FC_PAIR) || (mode == FC_PAIR_ALT);

  assign lead_c[SEQ_RESUME]  = xon1_char;
  assign trail_c[SEQ_RESUME] = xon2_char;
  assign lead_c[SEQ_PAUSE]   = xoff1_char;
  assign trail_c[SEQ_PAUSE]  = xoff2_char;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    swfc_seq_match #(.DW(DW)) i_match (
      .clk      (clk),
      .rst      (rst),
      .single_en(single_en),
      .pair_en  (pair_en),
      .rx_valid (rx_valid),
      .rx_byte  (rx_data),
      .lead     (lead_c[g]),
      .trail    (trail_c[g]),
      .hit      (seq_hit[g])
    );
  end

  assign any_hit = |seq_hit;

  swfc_gate i_gate (
    .clk       (clk),
    .rst       (rst),
    .fc_on     (fc_on),
    .rx_valid  (rx_valid),
    .pause_hit (seq_hit[SEQ_PAUSE]),
    .resume_hit(seq_hit[SEQ_RESUME]),
    .xon_any   (xon_any),
    .tx_idle   (tx_idle),
    .tx_go     (tx_go),
    .tx_halted (tx_halted)
  );

  swfc_irq i_irq (
    .clk   (clk),
    .rst   (rst),
    .set   (seq_hit[SEQ_PAUSE]),
    .clr   (isr_rd),
    .irq_en(xoff_irq_en),
    .flag  (xoff_seen),
    .irq   (irq)
  );

  // Forward everything except the byte that completes a match.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      wr_q <= rx_valid && !any_hit;
      if (rx_valid) data_q <= rx_data;
    end
  end

  assign rxf_wr   = wr_q;
  assign rxf_data = data_q;

  p_consume_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && any_hit) |=> !rxf_wr);
  p_forward_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !any_hit) |=> (rxf_wr && rxf_data == $past(rx_data)));
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !rxf_wr);
endmodule

// File: tb/test_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module test_xonxoff_flow_ctrl;
  localparam int DW = 4;
  localparam logic [DW-1:0] C_XON1 = 4'h1, C_XON2 = 4'h2, C_XOFF1 = 4'h3, C_XOFF2 = 4'h4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, rx_valid = 1'b0, xon_any = 1'b0, irq_en = 1'b1, tx_idle = 1'b1, isr_rd = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [1:0] mode = 2'b00;
  logic tx_go, tx_halted, rxf_wr, xoff_seen, irq;
  logic [DW-1:0] rxf_data;

  logic m_paused = 1'b0, m_flag = 1'b0;
  logic [1:0] m_arm = 2'b00;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  xonxoff_flow_ctrl #(.DW(DW)) i_xonxoff_flow_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .fc_mode(mode),
    .xon_any(xon_any), .xoff_irq_en(irq_en), .xon1_char(C_XON1), .xon2_char(C_XON2),
    .xoff1_char(C_XOFF1), .xoff2_char(C_XOFF2), .tx_idle(tx_idle), .isr_rd(isr_rd),
    .tx_go(tx_go), .tx_halted(tx_halted), .rxf_wr(rxf_wr), .rxf_data(rxf_data),
    .xoff_seen(xoff_seen), .irq(irq));

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {go,wr,data,flag,irq,halt} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One cycle: optional byte, optional status read; model per requirements.
  task automatic step(input logic v, input logic [DW-1:0] b, input logic rd, input string tag);
    logic single, pair, xo, xn, e_wr;
    single = (mode == 2'b01);
    pair   = mode[1];
    xo = v && (single ? (b == C_XOFF1) : (pair && m_arm[1] && b == C_XOFF2));
    xn = v && (single ? (b == C_XON1)  : (pair && m_arm[0] && b == C_XON2));
    if (!pair) m_arm = 2'b00;
    else if (v) m_arm = {b == C_XOFF1, b == C_XON1};
    if (mode == 2'b00)               m_paused = 1'b0;
    else if (xo)                     m_paused = 1'b1;
    else if (xn)                     m_paused = 1'b0;
    else if (m_paused && xon_any && v) m_paused = 1'b0;
    if (xo) m_flag = 1'b1; else if (rd) m_flag = 1'b0;
    e_wr = v && !xo && !xn;
    rx_valid = v; rx_data = b; isr_rd = rd;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; isr_rd = 1'b0;
    check({tx_go, rxf_wr, (e_wr ? rxf_data : 4'h0), xoff_seen, irq, tx_halted},
          {!m_paused, e_wr, (e_wr ? b : 4'h0), m_flag, m_flag & irq_en, m_paused & tx_idle}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({tx_go, rxf_wr, 4'h0, xoff_seen, irq, tx_halted}, 9'b1_0_0000_0_0_0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check({tx_go, rxf_wr, 4'h0, xoff_seen, irq, tx_halted}, 9'b1_0_0000_0_0_0, "R1 after reset");

    // R2: disabled mode forwards everything, never pauses
    for (int b = 0; b < 16; b++) step(1'b1, DW'(b), 1'b0, "R2 off");

    // R3/R5/R8: single mode sweep with mask toggling
    mode = 2'b01;
    for (int b = 0; b < 16; b++) begin
      irq_en = b[0];
      step(1'b1, DW'(b), b[1], "R3 single");
      step(1'b1, C_XOFF1, 1'b0, "R3 single pause");
      step(1'b1, DW'(b), 1'b0, "R5 single while paused");
    end

    // R2: switching off drops a pause
    step(1'b1, C_XOFF1, 1'b0, "R3 pause before off");
    mode = 2'b00;
    step(1'b0, '0, 1'b0, "R2 off releases");

    // R4/R5: every ordered pair, in both pair encodings, some with gaps
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        mode = (a[0]) ? 2'b11 : 2'b10;
        step(1'b1, DW'(a), 1'b0, "R4 pair first");
        if ((a + b) % 3 == 0) step(1'b0, '0, 1'b0, "R4 pair gap");
        step(1'b1, DW'(b), 1'b0, "R4 pair second");
      end
    end

    // R6: resume on any byte, single mode
    mode = 2'b01; xon_any = 1'b1;
    for (int b = 0; b < 16; b++) begin
      step(1'b1, C_XOFF1, 1'b0, "R6 pause");
      step(1'b1, DW'(b), 1'b0, "R6 any byte");
    end
    xon_any = 1'b0;

    // R7: set and read in the same cycle, then read alone
    irq_en = 1'b1;
    step(1'b1, C_XOFF1, 1'b1, "R7 set wins over read");
    step(1'b0, '0, 1'b1, "R7 read clears");
    step(1'b0, '0, 1'b0, "R7 stays clear");

    // R8: mask low hides a set flag
    step(1'b1, C_XOFF1, 1'b0, "R8 set");
    irq_en = 1'b0;
    step(1'b0, '0, 1'b0, "R8 masked");
    irq_en = 1'b1;
    step(1'b0, '0, 1'b0, "R8 unmasked");

    // R9: halted only once the shifter is idle
    tx_idle = 1'b0;
    step(1'b0, '0, 1'b0, "R9 busy while paused");
    tx_idle = 1'b1;
    step(1'b0, '0, 1'b0, "R9 idle while paused");
    step(1'b1, C_XON1, 1'b0, "R9 resumed");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule